// File: doc/BRIEF.md
# USB Host Controller Command and Status Unit

This unit is the register and sequencing core of a USB 1.x style host controller. It holds five software-visible registers: command, status, interrupt enable, frame number and frame-list base. It advances the frame counter on a 1 kHz strobe while running, and it drives a single level-sensitive interrupt line. A transfer engine sits beside it. That engine reads the frame-list entry address produced here and reports completion, short-packet and error events back.

Completion and short-packet events are not posted at once. They collect in a pending pair during the frame and move into a hidden two-bit latch at the next frame boundary. The USB interrupt status bit is set on that same edge. Each latch bit has its own enable. Register access uses a word-indexed bus: index 0 command, 1 status, 2 interrupt enable, 3 frame number, 4 frame-list base. Reads are combinational and have no side effects. A write takes effect on the clock edge that samples it.

Top module: `hc_cmdstat`

## Requirements
- R1: After reset, command reads 0, status reads 0x20 (halted), interrupt enable, frame number and base read 0, and `irq_o` and `running_o` are low.
- R2: Writing command bit 0 (run) as 1 when it was 0 clears status bit 5 (halted) and raises `running_o`. Any command write with bit 0 at 0 sets halted on that edge, and `running_o` stays high until the next strobe.
- R3: A strobe while running with command bit 0 set adds one to the 11-bit frame number, wrapping from 2047 to 0, and pulses `frame_start_o` for that cycle.
- R4: A strobe while running with command bit 0 clear drops `running_o` and keeps halted set. The frame number is left unchanged, and later strobes do not advance it.
- R5: A frame-number write loads bits 10:0 only while halted. While not halted the write is ignored.
- R6: The base register keeps write bits 31:12 and reads bits 11:0 as 0. `entry_addr_o` equals the base plus four times frame-number bits 9:0.
- R7: Completion (`ev_ioc_i`) and short-packet (`ev_spd_i`) events are held until the next advancing strobe. On that strobe they set latch bit 0 and latch bit 1 respectively, and status bit 0. Before that strobe, status bit 0 stays 0.
- R8: `irq_o` is high when any of these holds: latch bit 0 with enable bit 2; latch bit 1 with enable bit 3; status bit 1 with enable bit 0; status bit 2 with enable bit 1; status bit 3; status bit 4.
- R9: Status bits 4:0 are cleared by writing 1 to them. Writing 1 to bit 0 also clears both latch bits. Status writes do not change halted.
- R10: `ev_err_i` sets status bit 1, `ev_hse_i` sets bit 3 and `ev_pe_i` sets bit 4. Bits 3 and 4 raise `irq_o` with no enable set.
- R11: `resume_i` with command bit 3 (global suspend) set sets command bit 4 (force resume) and status bit 2 (resume detect). With bit 3 clear it has no effect.
- R12: A command write with bit 1 (controller reset) set shows that bit for one cycle. On the next edge every register returns to its R1 value.
- R13: `bus_reset_o` follows command bit 2 (global reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i |
| frame_strobe_i | input | 1 | 1 kHz frame tick, one cycle wide |
| ev_ioc_i | input | 1 | Completion with interrupt request seen this frame |
| ev_spd_i | input | 1 | Short packet seen this frame |
| ev_err_i | input | 1 | Transfer error |
| ev_hse_i | input | 1 | Host system error |
| ev_pe_i | input | 1 | Process error |
| resume_i | input | 1 | Resume request from the bus |
| entry_addr_o | output | 32 | Current frame-list entry address |
| running_o | output | 1 | Frame processing active |
| halted_o | output | 1 | Halted status |
| bus_reset_o | output | 1 | Global bus reset request |
| frame_start_o | output | 1 | Frame boundary pulse |
| irq_o | output | 1 | Interrupt level |

## Verification
The assertions take every event and strobe input to be a single-cycle pulse, synchronous to `clk_i`. They expect a frame-number write to arrive only while no frame tick is advancing the counter. The stimulus drives one input per cycle: each write, event or strobe is raised for one clock and then dropped. Register checks are made only in cycles with no write and no strobe, so each sampled value reflects a single cause.

// File: rtl/hc_pkg.sv
package hc_pkg;
  localparam int unsigned CMD_W = 5;
  localparam int unsigned STS_W = 6;
  localparam int unsigned IEN_W = 4;

  typedef enum logic [2:0] {
    A_CMD = 3'd0,
    A_STS = 3'd1,
    A_IEN = 3'd2,
    A_FRN = 3'd3,
    A_FLB = 3'd4
  } reg_addr_e;

  localparam int CMD_RS    = 0;
  localparam int CMD_HCRST = 1;
  localparam int CMD_GRST  = 2;
  localparam int CMD_EGSM  = 3;
  localparam int CMD_FGR   = 4;

  localparam int ST_INT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_RD   = 2;
  localparam int ST_HSE  = 3;
  localparam int ST_PE   = 4;
  localparam int ST_HALT = 5;

  localparam int IE_ERR = 0;
  localparam int IE_RD  = 1;
  localparam int IE_IOC = 2;
  localparam int IE_SPD = 3;
endpackage

// File: rtl/hc_ctrl_regs.sv
module hc_ctrl_regs
  import hc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned FRN_W   = 11,
  parameter int unsigned ALIGN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              frn_we_i,
  input  logic              flb_we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              strobe_i,
  input  logic              halted_i,
  input  logic              resume_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [FRN_W-1:0]  frnum_o,
  output logic [ADDR_W-1:0] flbase_o,
  output logic              running_o,
  output logic              hc_rst_o,
  output logic              tick_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              rsm_hit_o
);
  localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << ALIGN_W) - ADDR_W'(1));

  logic [CMD_W-1:0]  cmd_q;
  logic [FRN_W-1:0]  frn_q;
  logic [ADDR_W-1:0] flb_q;
  logic              run_q, hcrst_q;
  logic              tick_stop;

  assign start_o   = cmd_we_i && wdata_i[CMD_RS] && !cmd_q[CMD_RS] && !hcrst_q;
  assign tick_o    = strobe_i && run_q && cmd_q[CMD_RS] && !hcrst_q;
  assign tick_stop = strobe_i && run_q && !cmd_q[CMD_RS];
  assign stop_o    = (cmd_we_i && !wdata_i[CMD_RS]) || tick_stop;
  assign rsm_hit_o = resume_i && cmd_q[CMD_EGSM] && !cmd_we_i && !hcrst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      frn_q   <= '0;
      flb_q   <= '0;
      run_q   <= 1'b0;
      hcrst_q <= 1'b0;
    end else if (hcrst_q) begin
      cmd_q   <= '0;
      frn_q   <= '0;
      flb_q   <= '0;
      run_q   <= 1'b0;
      hcrst_q <= 1'b0;
    end else begin
      if (cmd_we_i) begin
        cmd_q   <= wdata_i[CMD_W-1:0];
        hcrst_q <= wdata_i[CMD_HCRST];
      end else if (rsm_hit_o) begin
        cmd_q[CMD_FGR] <= 1'b1;
      end
      if (start_o)        run_q <= 1'b1;
      else if (tick_stop) run_q <= 1'b0;
      // counter only moves while running, writes only land while halted
      if (tick_o)                    frn_q <= frn_q + 1'b1;
      else if (frn_we_i && halted_i) frn_q <= wdata_i[FRN_W-1:0];
      if (flb_we_i) flb_q <= wdata_i & BASE_MASK;
    end
  end

  assign cmd_o     = cmd_q;
  assign frnum_o   = frn_q;
  assign flbase_o  = flb_q;
  assign running_o = run_q;
  assign hc_rst_o  = hcrst_q;
endmodule

// File: rtl/hc_status_regs.sv
module hc_status_regs
  import hc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hc_rst_i,
  input  logic             sts_we_i,
  input  logic [ST_PE:0]   wdata_i,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             rsm_i,
  input  logic             ev_ioc_i,
  input  logic             ev_spd_i,
  input  logic             ev_err_i,
  input  logic             ev_hse_i,
  input  logic             ev_pe_i,
  output logic [STS_W-1:0] sts_o,
  output logic [1:0]       latch_o
);
  localparam logic [STS_W-1:0] STS_RST = STS_W'(1) << ST_HALT;

  logic [STS_W-1:0] sts_q;
  logic [1:0]       pend_q, latch_q, ev_frame;
  logic [ST_PE:0]   w1c, set_v;

  assign w1c      = sts_we_i ? wdata_i : '0;
  assign ev_frame = {ev_spd_i, ev_ioc_i};

  always_comb begin
    set_v         = '0;
    set_v[ST_INT] = tick_i && (|pend_q);
    set_v[ST_ERR] = ev_err_i;
    set_v[ST_RD]  = rsm_i;
    set_v[ST_HSE] = ev_hse_i;
    set_v[ST_PE]  = ev_pe_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= STS_RST;
      pend_q  <= '0;
      latch_q <= '0;
    end else if (hc_rst_i) begin
      sts_q   <= STS_RST;
      pend_q  <= '0;
      latch_q <= '0;
    end else begin
      // set beats clear when both land on one edge
      sts_q[ST_PE:0] <= (sts_q[ST_PE:0] & ~w1c) | set_v;
      if (stop_i)       sts_q[ST_HALT] <= 1'b1;
      else if (start_i) sts_q[ST_HALT] <= 1'b0;
      pend_q  <= tick_i ? ev_frame : (pend_q | ev_frame);
      latch_q <= (w1c[ST_INT] ? 2'b00 : latch_q) | (tick_i ? pend_q : 2'b00);
    end
  end

  assign sts_o   = sts_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/hc_irq_gen.sv
module hc_irq_gen
  import hc_pkg::*;
(
  input  logic [STS_W-1:0] sts_i,
  input  logic [1:0]       latch_i,
  input  logic [IEN_W-1:0] ien_i,
  output logic             irq_o
);
  logic [3:0] masked;

  assign masked[0] = latch_i[0]     && ien_i[IE_IOC];
  assign masked[1] = latch_i[1]     && ien_i[IE_SPD];
  assign masked[2] = sts_i[ST_ERR]  && ien_i[IE_ERR];
  assign masked[3] = sts_i[ST_RD]   && ien_i[IE_RD];

  assign irq_o = (|masked) || sts_i[ST_HSE] || sts_i[ST_PE];
endmodule

// File: rtl/hc_cmdstat.sv
module hc_cmdstat
  import hc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned FRN_W   = 11,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned ALIGN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [ADDR_W-1:0] bus_wdata_i,
  output logic [ADDR_W-1:0] bus_rdata_o,
  input  logic              frame_strobe_i,
  input  logic              ev_ioc_i,
  input  logic              ev_spd_i,
  input  logic              ev_err_i,
  input  logic              ev_hse_i,
  input  logic              ev_pe_i,
  input  logic              resume_i,
  output logic [ADDR_W-1:0] entry_addr_o,
  output logic              running_o,
  output logic              halted_o,
  output logic              bus_reset_o,
  output logic              frame_start_o,
  output logic              irq_o
);
  logic [CMD_W-1:0]  cmd;
  logic [STS_W-1:0]  sts;
  logic [IEN_W-1:0]  ien_q;
  logic [FRN_W-1:0]  frnum;
  logic [ADDR_W-1:0] flbase;
  logic [1:0]        latch;
  logic              hc_rst, tick, start, stop, rsm_hit;
  logic              we_cmd, we_sts, we_ien, we_frn, we_flb;

  assign we_cmd = bus_we_i && (bus_addr_i == A_CMD);
  assign we_sts = bus_we_i && (bus_addr_i == A_STS);
  assign we_ien = bus_we_i && (bus_addr_i == A_IEN);
  assign we_frn = bus_we_i && (bus_addr_i == A_FRN);
  assign we_flb = bus_we_i && (bus_addr_i == A_FLB);

  hc_ctrl_regs #(.ADDR_W(ADDR_W), .FRN_W(FRN_W), .ALIGN_W(ALIGN_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_we_i (we_cmd),
    .frn_we_i (we_frn),
    .flb_we_i (we_flb),
    .wdata_i  (bus_wdata_i),
    .strobe_i (frame_strobe_i),
    .halted_i (sts[ST_HALT]),
    .resume_i (resume_i),
    .cmd_o    (cmd),
    .frnum_o  (frnum),
    .flbase_o (flbase),
    .running_o(running_o),
    .hc_rst_o (hc_rst),
    .tick_o   (tick),
    .start_o  (start),
    .stop_o   (stop),
    .rsm_hit_o(rsm_hit)
  );

  hc_status_regs u_sts (
    .clk_i, .rst_ni,
    .hc_rst_i(hc_rst),
    .sts_we_i(we_sts),
    .wdata_i (bus_wdata_i[ST_PE:0]),
    .tick_i  (tick),
    .start_i (start),
    .stop_i  (stop),
    .rsm_i   (rsm_hit),
    .ev_ioc_i, .ev_spd_i, .ev_err_i, .ev_hse_i, .ev_pe_i,
    .sts_o   (sts),
    .latch_o (latch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= '0;
    else if (hc_rst) ien_q <= '0;
    else if (we_ien) ien_q <= bus_wdata_i[IEN_W-1:0];
  end

  hc_irq_gen u_irq (
    .sts_i  (sts),
    .latch_i(latch),
    .ien_i  (ien_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      A_CMD:   bus_rdata_o = ADDR_W'(cmd);
      A_STS:   bus_rdata_o = ADDR_W'(sts);
      A_IEN:   bus_rdata_o = ADDR_W'(ien_q);
      A_FRN:   bus_rdata_o = ADDR_W'(frnum);
      A_FLB:   bus_rdata_o = flbase;
      default: bus_rdata_o = '0;
    endcase
  end

  assign entry_addr_o  = flbase + (ADDR_W'(frnum[IDX_W-1:0]) << 2);
  assign halted_o      = sts[ST_HALT];
  assign bus_reset_o   = cmd[CMD_GRST];
  assign frame_start_o = tick;
endmodule

// File: rtl/hc_cmdstat_chk.sv
module hc_cmdstat_chk #(
  parameter int unsigned FRN_W = 11,
  parameter int unsigned IDX_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_we_i,
  input logic [2:0]       bus_addr_i,
  input logic             wr_rs,
  input logic             frame_strobe_i,
  input logic             running_o,
  input logic             halted_o,
  input logic             frame_start_o,
  input logic             irq_o,
  input logic [IDX_W+1:0] entry_lo,
  input logic             cmd_rs,
  input logic             sts_int,
  input logic [1:0]       sts_fatal,
  input logic [3:0]       ien,
  input logic [FRN_W-1:0] frnum,
  input logic             hc_rst
);
  // R2
  stop_sets_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == 3'd0 && !wr_rs |=> halted_o);

  // R3
  frame_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> frnum == FRN_W'($past(frnum) + 1'b1));

  // R4
  stop_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_strobe_i && running_o && !cmd_rs && !hc_rst |=> !running_o && halted_o);

  // R6
  entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_lo == {frnum[IDX_W-1:0], 2'b00});

  // R7
  int_at_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_int) |-> $past(frame_start_o));

  // R8
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien == 4'd0 && sts_fatal == 2'b00 |-> !irq_o);

  // R10
  fatal_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sts_fatal) |-> irq_o);

  // R12
  hcrst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hc_rst |=> !cmd_rs && halted_o && frnum == '0 && ien == 4'd0);
endmodule

bind hc_cmdstat hc_cmdstat_chk #(.FRN_W(FRN_W), .IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .wr_rs         (bus_wdata_i[0]),
  .frame_strobe_i(frame_strobe_i),
  .running_o     (running_o),
  .halted_o      (halted_o),
  .frame_start_o (frame_start_o),
  .irq_o         (irq_o),
  .entry_lo      (entry_addr_o[IDX_W+1:0]),
  .cmd_rs        (cmd[0]),
  .sts_int       (sts[0]),
  .sts_fatal     (sts[4:3]),
  .ien           (ien_q),
  .frnum         (frnum),
  .hc_rst        (hc_rst)
);

// File: tb/sim_hc_cmdstat.sv
`timescale 1ns/1ps
module sim_hc_cmdstat;
  localparam int K_REG = 0, K_IRQ = 1, K_RUN = 2, K_GRST = 3, K_ENT = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, entry;
  logic        strobe = 1'b0, ioc = 1'b0, spd = 1'b0, err = 1'b0, hse = 1'b0, pe = 1'b0, rsm = 1'b0;
  logic        running, halted, grst, fstart, irq;

  always #5 clk = ~clk;

  hc_cmdstat u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .frame_strobe_i(strobe), .ev_ioc_i(ioc), .ev_spd_i(spd),
    .ev_err_i(err), .ev_hse_i(hse), .ev_pe_i(pe), .resume_i(rsm), .entry_addr_o(entry),
    .running_o(running), .halted_o(halted), .bus_reset_o(grst), .frame_start_o(fstart),
    .irq_o(irq)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    n_run = 0, n_fail = 0;
  bit    done = 1'b0;

  function automatic logic [31:0] observe(int kind);
    case (kind)
      K_REG:   return rdata;
      K_IRQ:   return {31'd0, irq};
      K_RUN:   return {31'd0, running};
      K_GRST:  return {31'd0, grst};
      default: return entry;
    endcase
  endfunction

  // monitor: pops the expected item and compares after the edge settles
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      #1;
      it  = sb_q.pop_front();
      act = observe(it.kind);
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    we = 1'b0; addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ioc = 1'b1;
      1: spd = 1'b1;
      2: err = 1'b1;
      3: hse = 1'b1;
      4: pe  = 1'b1;
      default: rsm = 1'b1;
    endcase
    @(negedge clk);
    {ioc, spd, err, hse, pe, rsm} = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    chk(K_REG, 3'd0, 32'h0, "R1 cmd");
    chk(K_REG, 3'd1, 32'h20, "R1 status");
    chk(K_REG, 3'd2, 32'h0, "R1 ien");
    chk(K_REG, 3'd3, 32'h0, "R1 frnum");
    chk(K_REG, 3'd4, 32'h0, "R1 base");
    chk(K_IRQ, 3'd0, 32'h0, "R1 irq");
    chk(K_RUN, 3'd0, 32'h0, "R1 running");

    // R6 base alignment, R5 frame write while halted
    wr(3'd4, 32'h1234_5FFF);
    chk(K_REG, 3'd4, 32'h1234_5000, "R6 base");
    wr(3'd3, 32'h0000_FFFF);
    chk(K_REG, 3'd3, 32'h7FF, "R5 frnum halted write");
    chk(K_ENT, 3'd0, 32'h1234_5FFC, "R6 entry");

    // R2 start
    wr(3'd0, 32'h1);
    chk(K_REG, 3'd1, 32'h0, "R2 halted cleared");
    chk(K_RUN, 3'd0, 32'h1, "R2 running");

    // R5 write ignored while running
    wr(3'd3, 32'h5);
    chk(K_REG, 3'd3, 32'h7FF, "R5 frnum running write ignored");

    // R3 wrap and count
    tick();
    chk(K_REG, 3'd3, 32'h0, "R3 wrap");
    chk(K_ENT, 3'd0, 32'h1234_5000, "R6 entry after wrap");
    tick();
    chk(K_REG, 3'd3, 32'h1, "R3 count");

    // R7 deferred completion, R8 enable
    pulse(0);
    chk(K_REG, 3'd1, 32'h0, "R7 not posted before tick");
    wr(3'd2, 32'h4);
    chk(K_IRQ, 3'd0, 32'h0, "R7 irq before tick");
    tick();
    chk(K_REG, 3'd1, 32'h1, "R7 posted at tick");
    chk(K_IRQ, 3'd0, 32'h1, "R8 ioc irq");

    // R9 clearing bit 0 clears latch
    wr(3'd1, 32'h1);
    chk(K_REG, 3'd1, 32'h0, "R9 w1c int");
    chk(K_IRQ, 3'd0, 32'h0, "R9 latch cleared");

    // R8 short packet needs its own enable
    pulse(1);
    tick();
    chk(K_REG, 3'd1, 32'h1, "R7 spd posted");
    chk(K_IRQ, 3'd0, 32'h0, "R8 spd masked");
    wr(3'd2, 32'hC);
    chk(K_IRQ, 3'd0, 32'h1, "R8 spd enabled");
    wr(3'd1, 32'h1);
    chk(K_IRQ, 3'd0, 32'h0, "R9 spd latch cleared");

    // R10 error, R8 error enable
    wr(3'd2, 32'h0);
    pulse(2);
    chk(K_REG, 3'd1, 32'h2, "R10 usb error");
    chk(K_IRQ, 3'd0, 32'h0, "R8 error masked");
    wr(3'd2, 32'h1);
    chk(K_IRQ, 3'd0, 32'h1, "R8 error enabled");
    wr(3'd1, 32'h2);
    chk(K_REG, 3'd1, 32'h0, "R9 w1c error");
    wr(3'd2, 32'h0);
    pulse(3);
    chk(K_REG, 3'd1, 32'h8, "R10 host error");
    chk(K_IRQ, 3'd0, 32'h1, "R10 host error irq");
    wr(3'd1, 32'h8);
    pulse(4);
    chk(K_REG, 3'd1, 32'h10, "R10 process error");
    chk(K_IRQ, 3'd0, 32'h1, "R10 process error irq");
    wr(3'd1, 32'h10);
    chk(K_IRQ, 3'd0, 32'h0, "R9 w1c process error");

    // R11 resume
    pulse(5);
    chk(K_REG, 3'd0, 32'h1, "R11 resume ignored cmd");
    chk(K_REG, 3'd1, 32'h0, "R11 resume ignored status");
    wr(3'd0, 32'h9);
    pulse(5);
    chk(K_REG, 3'd0, 32'h19, "R11 force resume");
    chk(K_REG, 3'd1, 32'h4, "R11 resume detect");
    wr(3'd2, 32'h2);
    chk(K_IRQ, 3'd0, 32'h1, "R8 resume irq");
    wr(3'd1, 32'h4);
    chk(K_IRQ, 3'd0, 32'h0, "R9 w1c resume");

    // R13 global reset
    wr(3'd0, 32'h5);
    chk(K_GRST, 3'd0, 32'h1, "R13 bus reset on");
    wr(3'd0, 32'h1);
    chk(K_GRST, 3'd0, 32'h0, "R13 bus reset off");

    // R2 and R4 stop
    wr(3'd0, 32'h0);
    chk(K_REG, 3'd1, 32'h20, "R2 halted on stop write");
    chk(K_RUN, 3'd0, 32'h1, "R4 running until tick");
    tick();
    chk(K_RUN, 3'd0, 32'h0, "R4 stopped at tick");
    chk(K_REG, 3'd3, 32'h3, "R4 frnum held");
    tick();
    chk(K_REG, 3'd3, 32'h3, "R4 no advance when stopped");
    wr(3'd1, 32'h3F);
    chk(K_REG, 3'd1, 32'h20, "R9 halted not cleared");

    // R5 write while halted
    wr(3'd3, 32'h123);
    chk(K_REG, 3'd3, 32'h123, "R5 halted write");
    chk(K_ENT, 3'd0, 32'h1234_548C, "R6 entry offset");

    // R12 controller reset
    wr(3'd2, 32'hF);
    wr(3'd0, 32'h2);
    chk(K_REG, 3'd0, 32'h0, "R12 cmd");
    chk(K_REG, 3'd1, 32'h20, "R12 status");
    chk(K_REG, 3'd2, 32'h0, "R12 ien");
    chk(K_REG, 3'd3, 32'h0, "R12 frnum");
    chk(K_REG, 3'd4, 32'h0, "R12 base");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule